// File: doc/BRIEF.md
# CAN Controller Operating-Mode and Wakeup Control

This block holds the operating mode of a CAN controller and the small control register that steers it. The controller is always in one of three modes: sleep, initialization or normal. A host writes a control word carrying a sleep request, an init request, an automatic-wakeup enable and a one-shot reset command. The block moves between modes from the registered request bits. It reports the current mode and two acknowledge flags that software polls to learn when a requested mode has been reached.

Two paths lead out of sleep. With automatic wakeup off, only a host write that clears the sleep request ends sleep. With it on, a bus-activity indication seen while asleep makes the hardware clear the sleep request by itself and leave sleep. A controller-wide soft reset can also be commanded. It lasts one cycle, clears itself, returns the control register to its power-up contents and puts the controller back into sleep. Frame handling, error counting and bus-register decoding belong to other blocks.

Top module: `can_mode_ctrl`

## Requirements
- R1: After the reset input is released, mode reads 0 (sleep), sleep_ack is 1, init_ack is 0, sleep_req_q is 1, and init_req_q, autowake_q and reset_q are 0. Mode encoding: 0 = sleep, 1 = initialization, 2 = normal.
- R2: A write with ctl_reset = 1 sets reset_q at that clock edge. At the next edge reset_q returns to 0, the control bits return to their R1 values and mode becomes sleep. Any host write made during that reset cycle is discarded.
- R3: With autowake_q = 0, bus_activity has no effect in sleep, and sleep ends only when a write clears the sleep request.
- R4: With autowake_q = 1 and mode sleep, bus_activity high at a clock edge clears sleep_req_q and moves mode out of sleep at that same edge. sleep_ack falls one edge later.
- R5: sleep_ack and init_ack equal "mode is sleep" and "mode is initialization" as they stood one clock cycle earlier.
- R6: When init and sleep requests are both set, the init request wins: from normal or initialization, mode goes to or stays in initialization.
- R7: On leaving sleep, mode goes to initialization if init_req_q is 1 and to normal otherwise.
- R8: Outside sleep, bus_activity changes neither the mode nor sleep_req_q.
- R9: Mode acts on the registered request bits, so a mode change takes effect one clock edge after the write that requests it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control-word write strobe |
| ctl_sleep | input | 1 | Sleep request value to write |
| ctl_init | input | 1 | Init request value to write |
| ctl_reset | input | 1 | Writing 1 commands a one-cycle soft reset |
| ctl_autowake | input | 1 | Automatic-wakeup enable value to write |
| bus_activity | input | 1 | Bus activity detected this cycle |
| sleep_req_q | output | 1 | Registered sleep request |
| init_req_q | output | 1 | Registered init request |
| reset_q | output | 1 | Soft-reset command bit, self-clearing |
| autowake_q | output | 1 | Registered automatic-wakeup enable |
| mode | output | 2 | Current mode (0 sleep, 1 init, 2 normal) |
| sleep_ack | output | 1 | Sleep acknowledge |
| init_ack | output | 1 | Init acknowledge |

## Verification
On every cycle the assertions check the local timing rules: the reset bit clearing itself, the jump to sleep after a soft reset, the acknowledge latency, init-over-sleep priority, the one-edge wakeup on bus activity and the immunity of the sleep request to bus activity outside sleep. The directed scenarios are needed to show the full sequences that span several writes. These are software wakeup with automatic wakeup off, the choice of exit mode, and the control register reading back its power-up contents after a soft reset.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

   typedef enum logic [1:0] {
      MODE_SLEEP  = 2'd0,
      MODE_INIT   = 2'd1,
      MODE_NORMAL = 2'd2
   } can_mode_e;

   // Exit target when sleep ends
   function automatic can_mode_e wake_target(input logic init_req);
      return init_req ? MODE_INIT : MODE_NORMAL;
   endfunction

   // Next mode from registered requests; init outranks sleep
   function automatic can_mode_e next_mode(input can_mode_e cur,
                                           input logic      sleep_req,
                                           input logic      init_req,
                                           input logic      wake_evt);
      can_mode_e nxt;
      nxt = cur;
      unique case (cur)
         MODE_SLEEP: begin
            if (wake_evt || !sleep_req) nxt = wake_target(init_req);
         end
         MODE_INIT: begin
            if (!init_req) nxt = sleep_req ? MODE_SLEEP : MODE_NORMAL;
         end
         MODE_NORMAL: begin
            if (init_req)       nxt = MODE_INIT;
            else if (sleep_req) nxt = MODE_SLEEP;
         end
         default: nxt = MODE_SLEEP;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/can_mode_ctlreg.sv
module can_mode_ctlreg #(
   parameter bit AUTOWAKE_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr,
   input  logic wr_sleep,
   input  logic wr_init,
   input  logic wr_reset,
   input  logic wr_autowake,
   input  logic wake_evt,
   output logic sleep_q,
   output logic init_q,
   output logic reset_q,
   output logic autowake_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reset_q <= 1'b0;
      end else begin
         reset_q <= !reset_q && wr && wr_reset;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_q <= 1'b1;
         init_q  <= 1'b0;
      end else if (reset_q) begin
         sleep_q <= 1'b1;
         init_q  <= 1'b0;
      end else begin
         if (wake_evt)  sleep_q <= 1'b0;
         else if (wr)   sleep_q <= wr_sleep;
         if (wr)        init_q  <= wr_init;
      end
   end

   generate
      if (AUTOWAKE_EN) begin : g_aw
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       autowake_q <= 1'b0;
            else if (reset_q) autowake_q <= 1'b0;
            else if (wr)      autowake_q <= wr_autowake;
         end
      end else begin : g_no_aw
         assign autowake_q = 1'b0;
      end
   endgenerate

   // R2: the command bit never stays set for two cycles
   a_r2_reset_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
      reset_q |=> !reset_q);

   // R2: control contents return to power-up values
   a_r2_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
      reset_q |=> (sleep_q && !init_q && !autowake_q));

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm
   import can_mode_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      soft_rst,
   input  logic      sleep_req,
   input  logic      init_req,
   input  logic      autowake,
   input  logic      bus_activity,
   output logic      wake_evt,
   output can_mode_e mode_q
);

   can_mode_e mode_d;

   assign wake_evt = (mode_q == MODE_SLEEP) && autowake && bus_activity && !soft_rst;

   always_comb begin
      mode_d = next_mode(mode_q, sleep_req, init_req, wake_evt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_q <= MODE_SLEEP;
      else if (soft_rst) mode_q <= MODE_SLEEP;
      else               mode_q <= mode_d;
   end

   // R2: soft reset lands in sleep
   a_r2_rst_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (mode_q == MODE_SLEEP));

   // R6: init request wins outside sleep
   a_r6_init_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (init_req && !soft_rst && mode_q != MODE_SLEEP) |=> (mode_q == MODE_INIT));

   // R7: exit from sleep honours the init request
   a_r7_exit_target: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SLEEP && !soft_rst && (wake_evt || !sleep_req))
      |=> (mode_q == (init_req ? MODE_INIT : MODE_NORMAL)));

   // R3: without autowake, sleep holds while requested
   a_r3_stay_asleep: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_SLEEP && sleep_req && !autowake) |=> (mode_q == MODE_SLEEP));

endmodule

// File: rtl/can_mode_ack.sv
module can_mode_ack
   import can_mode_pkg::*;
#(
   parameter int STAGES = 1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  can_mode_e mode,
   output logic      sleep_ack,
   output logic      init_ack
);

   localparam int LAST = STAGES - 1;

   logic [1:0] pipe [STAGES];

   generate
      if (STAGES < 1 || STAGES > 8) begin : g_bad
         $error("can_mode_ack: STAGES must be 1..8");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pipe[i] <= 2'b01;
            end else if (i == 0) begin
               pipe[i] <= {mode == MODE_INIT, mode == MODE_SLEEP};
            end else begin
               pipe[i] <= pipe[(i > 0) ? i - 1 : 0];
            end
         end
      end
      if (STAGES == 1) begin : g_chk
         // R5: acknowledge follows mode by one cycle
         a_r5_ack_latency: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (sleep_ack == $past(mode == MODE_SLEEP) &&
                      init_ack  == $past(mode == MODE_INIT)));
      end
   endgenerate

   assign sleep_ack = pipe[LAST][0];
   assign init_ack  = pipe[LAST][1];

   a_r5_ack_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(sleep_ack && init_ack));

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
   import can_mode_pkg::*;
#(
   parameter bit AUTOWAKE_EN = 1'b1,
   parameter int ACK_STAGES  = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_wr,
   input  logic       ctl_sleep,
   input  logic       ctl_init,
   input  logic       ctl_reset,
   input  logic       ctl_autowake,
   input  logic       bus_activity,
   output logic       sleep_req_q,
   output logic       init_req_q,
   output logic       reset_q,
   output logic       autowake_q,
   output logic [1:0] mode,
   output logic       sleep_ack,
   output logic       init_ack
);

   can_mode_e mode_q;
   logic      wake_evt;

   can_mode_ctlreg #(.AUTOWAKE_EN(AUTOWAKE_EN)) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr          (ctl_wr),
      .wr_sleep    (ctl_sleep),
      .wr_init     (ctl_init),
      .wr_reset    (ctl_reset),
      .wr_autowake (ctl_autowake),
      .wake_evt    (wake_evt),
      .sleep_q     (sleep_req_q),
      .init_q      (init_req_q),
      .reset_q     (reset_q),
      .autowake_q  (autowake_q)
   );

   can_mode_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .soft_rst     (reset_q),
      .sleep_req    (sleep_req_q),
      .init_req     (init_req_q),
      .autowake     (autowake_q),
      .bus_activity (bus_activity),
      .wake_evt     (wake_evt),
      .mode_q       (mode_q)
   );

   can_mode_ack #(.STAGES(ACK_STAGES)) u_ack (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode_q),
      .sleep_ack (sleep_ack),
      .init_ack  (init_ack)
   );

   assign mode = mode_q;

   // R4: bus activity in sleep with autowake ends sleep at once
   a_r4_autowake: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && autowake_q && bus_activity && !reset_q)
      |=> (!sleep_req_q && mode != 2'd0));

   // R8: outside sleep the sleep request ignores bus activity
   a_r8_bus_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != 2'd0 && !ctl_wr && !reset_q) |=> $stable(sleep_req_q));

   // R9: mode only changes one edge after the requests were registered
   a_r9_reg_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2 && !init_req_q && !sleep_req_q && !reset_q) |=> (mode == 2'd2));

endmodule

// File: tb/tb_can_mode_ctrl.sv
module tb_can_mode_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0, ctl_sleep = 1'b0, ctl_init = 1'b0;
   logic       ctl_reset = 1'b0, ctl_autowake = 1'b0, bus_activity = 1'b0;
   logic       sleep_req_q, init_req_q, reset_q, autowake_q, sleep_ack, init_ack;
   logic [1:0] mode;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   can_mode_ctrl dut (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_sleep(ctl_sleep),
      .ctl_init(ctl_init), .ctl_reset(ctl_reset), .ctl_autowake(ctl_autowake),
      .bus_activity(bus_activity), .sleep_req_q(sleep_req_q),
      .init_req_q(init_req_q), .reset_q(reset_q), .autowake_q(autowake_q),
      .mode(mode), .sleep_ack(sleep_ack), .init_ack(init_ack)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Write at one negedge, strobe seen at the next posedge, return at following negedge
   task automatic wr(input logic s, input logic i, input logic r, input logic a);
      ctl_wr = 1'b1; ctl_sleep = s; ctl_init = i; ctl_reset = r; ctl_autowake = a;
      @(negedge clk);
      ctl_wr = 1'b0; ctl_reset = 1'b0;
   endtask

   task automatic pulse_bus();
      bus_activity = 1'b1;
      @(negedge clk);
      bus_activity = 1'b0;
   endtask

   task automatic t_reset_state();
      chk("R1", "mode", mode, 0);
      chk("R1", "sleep_ack", sleep_ack, 1);
      chk("R1", "init_ack", init_ack, 0);
      chk("R1", "sleep_req_q", sleep_req_q, 1);
      chk("R1", "init_req_q", init_req_q, 0);
      chk("R1", "autowake_q", autowake_q, 0);
      chk("R1", "reset_q", reset_q, 0);
   endtask

   task automatic t_sw_wake();
      pulse_bus();
      @(negedge clk);
      chk("R3", "mode after bus activity", mode, 0);
      chk("R3", "sleep_req_q after bus activity", sleep_req_q, 1);
      wr(1'b0, 1'b0, 1'b0, 1'b0);
      chk("R9", "sleep_req_q after write", sleep_req_q, 0);
      chk("R9", "mode same edge as write", mode, 0);
      @(negedge clk);
      chk("R7", "mode to normal", mode, 2);
      chk("R5", "sleep_ack lags", sleep_ack, 1);
      @(negedge clk);
      chk("R5", "sleep_ack cleared", sleep_ack, 0);
   endtask

   task automatic t_init_priority();
      wr(1'b0, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      chk("R6", "mode init", mode, 1);
      chk("R5", "init_ack lags", init_ack, 0);
      @(negedge clk);
      chk("R5", "init_ack set", init_ack, 1);
      wr(1'b1, 1'b1, 1'b0, 1'b0);
      @(negedge clk); @(negedge clk);
      chk("R6", "init held over sleep", mode, 1);
      wr(1'b1, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk("R6", "sleep after init dropped", mode, 0);
      @(negedge clk);
      chk("R5", "sleep_ack back", sleep_ack, 1);
      chk("R5", "init_ack gone", init_ack, 0);
      wr(1'b0, 1'b1, 1'b0, 1'b0);
      @(negedge clk);
      chk("R7", "sleep exit to init", mode, 1);
   endtask

   task automatic t_autowake();
      wr(1'b1, 1'b0, 1'b0, 1'b1);
      @(negedge clk); @(negedge clk);
      chk("R4", "asleep before activity", mode, 0);
      pulse_bus();
      chk("R4", "sleep_req_q cleared", sleep_req_q, 0);
      chk("R4", "mode woke to normal", mode, 2);
      chk("R4", "sleep_ack still set", sleep_ack, 1);
      @(negedge clk);
      chk("R4", "sleep_ack cleared", sleep_ack, 0);
      wr(1'b1, 1'b1, 1'b0, 1'b1);
      @(negedge clk);
      chk("R8", "init mode held", mode, 1);
      pulse_bus();
      @(negedge clk);
      chk("R8", "sleep_req_q kept", sleep_req_q, 1);
      chk("R8", "mode still init", mode, 1);
      wr(1'b1, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      chk("R4", "asleep again", mode, 0);
      ctl_init = 1'b1;
      wr(1'b1, 1'b1, 1'b0, 1'b1);
      pulse_bus();
      chk("R7", "autowake to init", mode, 1);
      chk("R4", "sleep_req_q cleared (init)", sleep_req_q, 0);
   endtask

   task automatic t_soft_reset();
      wr(1'b0, 1'b0, 1'b0, 1'b1);
      @(negedge clk); @(negedge clk);
      chk("R2", "normal before reset", mode, 2);
      wr(1'b0, 1'b1, 1'b1, 1'b1);
      chk("R2", "reset_q set", reset_q, 1);
      ctl_wr = 1'b1; ctl_sleep = 1'b0; ctl_init = 1'b1;
      @(negedge clk);
      ctl_wr = 1'b0;
      chk("R2", "reset_q self-cleared", reset_q, 0);
      chk("R2", "sleep_req_q restored", sleep_req_q, 1);
      chk("R2", "init_req_q restored", init_req_q, 0);
      chk("R2", "autowake_q restored", autowake_q, 0);
      chk("R2", "mode sleep", mode, 0);
      @(negedge clk);
      chk("R2", "sleep_ack after reset", sleep_ack, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_sw_wake();
      t_init_priority();
      wr(1'b1, 1'b0, 1'b0, 1'b0);
      @(negedge clk); @(negedge clk);
      t_autowake();
      t_soft_reset();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule